// File: doc/BRIEF.md
# Two-Level Peripheral Interrupt Controller

This block gathers interrupt events from two peripheral groups and drives one request line to a host processor. The first group has six external input lines. The second group has four PC-card sources. Each source can latch a rising edge into a sticky status bit. Two enables govern each source. A status enable decides whether an edge is recorded at all. An interrupt enable decides whether a recorded event is forwarded upward.

Each group's forwarded events are ORed into one summary bit in a top-level status word. The summary bits are then gated by a single master enable to form the host line. The host line is registered. Software reads the top-level word to find the active group, then reads that group's status. It acknowledges an event by writing a one to the matching status bit.

Access is through a plain synchronous register port: an address, a write strobe with write data, and combinational read data.

Top module: `irq_hub_top`

## Requirements
- R1: After reset every register reads zero and `host_irq_o` is low.
- R2: A source's status bit becomes 1 on the first clock edge at which its input is high after having been low, provided its status-enable bit is 1. An input that stays high does not set the bit again after it has been cleared.
- R3: A rising edge seen while the source's status-enable bit is 0 is not recorded, and setting the enable afterwards does not record it retroactively.
- R4: Writing to a group status register clears each status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R5: When a new edge and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R6: Offset 0x104 is read-only and returns the external status ANDed with the external interrupt-enable bits.
- R7: Offset 0x000 is read-only. Bit 0 is the OR of (card status AND card interrupt enable). Bit 7 is the same OR for the external group. All other bits read 0.
- R8: The master enable is bit 0 of offset 0x010; other bits of that register read 0. `host_irq_o` equals the master bit ANDed with the OR of the two summary bits, taken one clock earlier.
- R9: External status is at 0x100, with bits 0 to 3 for external lines 0 to 3 and bits 4 and 5 for lines 4 and 5 (input bit i maps to status bit i). Card status is at 0x200, with bit 0 card-1 IO, bit 1 card-1 ring, bit 2 card-2 IO and bit 3 card-2 ring. The enable registers are at 0x110 (external) and 0x210 (card). In each, the interrupt enables sit from bit 0 and the status enables from bit 8, in the same source order.
- R10: Reads of any unlisted offset return zero. Writes to unlisted or read-only offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_we_i | input | 1 | Write strobe, one write per cycle while high |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| ext_src_i | input | 6 | External interrupt inputs, one per line |
| card_src_i | input | 4 | PC-card interrupt inputs |
| host_irq_o | output | 1 | Registered interrupt request to the host |

## Verification
The bench builds the block with its default parameters: six external sources, four card sources and status enables starting at bit 8. With these values the bench can address every status bit position and both enable fields. It also exercises the summary bit of each group separately. This lets it check that edges land in the correct bit and that the masked view hides exactly the sources whose interrupt enable is off. The same-cycle set/clear collision and the retroactive-enable case are both reachable with the default widths.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    // register offsets
    localparam int unsigned OFF_TOP_STAT  = 'h000;
    localparam int unsigned OFF_MASTER    = 'h010;
    localparam int unsigned OFF_EXT_STAT  = 'h100;
    localparam int unsigned OFF_EXT_MASK  = 'h104;
    localparam int unsigned OFF_EXT_EN    = 'h110;
    localparam int unsigned OFF_CARD_STAT = 'h200;
    localparam int unsigned OFF_CARD_EN   = 'h210;

    // summary positions in the top-level word (decoded by software)
    localparam int unsigned TOP_CARD_BIT = 0;
    localparam int unsigned TOP_EXT_BIT  = 7;

    // enable register layout: interrupt enables at bit 0, status enables here
    localparam int unsigned SEN_LSB = 8;

    typedef struct packed {
        logic master;
        logic irq;
    } hub_state_t;

endpackage

// File: rtl/irq_hub_group.sv
module irq_hub_group #(
    parameter int unsigned NSRC    = 6,
    parameter int unsigned DW      = 32,
    parameter int unsigned SEN_POS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            wr_stat_i,
    input  logic            wr_en_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [NSRC-1:0] status_o,
    output logic [NSRC-1:0] ien_o,
    output logic [NSRC-1:0] sen_o,
    output logic            summary_o
);

    typedef struct packed {
        logic [NSRC-1:0] status;
        logic [NSRC-1:0] ien;
        logic [NSRC-1:0] sen;
        logic [NSRC-1:0] prev;
    } grp_state_t;

    grp_state_t      grp_d, grp_q;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] clr_mask;
    logic            unused_wd;

    assign unused_wd = ^wdata_i;

    always_comb begin
        grp_d    = grp_q;
        rise     = src_i & ~grp_q.prev;
        clr_mask = wr_stat_i ? wdata_i[NSRC-1:0] : '0;
        grp_d.prev   = src_i;
        // a fresh edge wins over a simultaneous clear
        grp_d.status = (grp_q.status & ~clr_mask) | (rise & grp_q.sen);
        if (wr_en_i) begin
            grp_d.ien = wdata_i[NSRC-1:0];
            grp_d.sen = wdata_i[SEN_POS +: NSRC];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q <= '0;
        end else begin
            grp_q <= grp_d;
        end
    end

    assign status_o  = grp_q.status;
    assign ien_o     = grp_q.ien;
    assign sen_o     = grp_q.sen;
    assign summary_o = |(grp_q.status & grp_q.ien);

    // R4: bits not cleared by a write-one stay set
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp_q.status & $past(grp_q.status & ~clr_mask)) == $past(grp_q.status & ~clr_mask)));

    // R3: a bit only turns on if its status enable was on
    a_r3_needs_sen: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp_q.status & ~$past(grp_q.status) & ~$past(grp_q.sen)) == '0));

    // R2: a bit only turns on after an input edge
    a_r2_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp_q.status & ~$past(grp_q.status) & ~$past(rise)) == '0));

    // R5: an enabled edge always lands, even against a clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp_q.status & $past(rise & grp_q.sen)) == $past(rise & grp_q.sen)));

endmodule

// File: rtl/irq_hub_top.sv
module irq_hub_top
    import irq_hub_pkg::*;
#(
    parameter int unsigned AW      = ADDR_W,
    parameter int unsigned DW      = DATA_W,
    parameter int unsigned N_EXT   = 6,
    parameter int unsigned N_CARD  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     reg_addr_i,
    input  logic [DW-1:0]     reg_wdata_i,
    input  logic              reg_we_i,
    output logic [DW-1:0]     reg_rdata_o,
    input  logic [N_EXT-1:0]  ext_src_i,
    input  logic [N_CARD-1:0] card_src_i,
    output logic              host_irq_o
);

    hub_state_t        hub_d, hub_q;
    logic [N_EXT-1:0]  ext_stat, ext_ien, ext_sen;
    logic [N_CARD-1:0] card_stat, card_ien, card_sen;
    logic              ext_sum, card_sum;
    logic              hit_ext_stat, hit_ext_en, hit_card_stat, hit_card_en, hit_master;
    logic              addr_hit;
    logic              unused_wd;

    assign unused_wd = ^reg_wdata_i;

    assign hit_master    = (reg_addr_i == AW'(OFF_MASTER));
    assign hit_ext_stat  = (reg_addr_i == AW'(OFF_EXT_STAT));
    assign hit_ext_en    = (reg_addr_i == AW'(OFF_EXT_EN));
    assign hit_card_stat = (reg_addr_i == AW'(OFF_CARD_STAT));
    assign hit_card_en   = (reg_addr_i == AW'(OFF_CARD_EN));
    assign addr_hit      = hit_master | hit_ext_stat | hit_ext_en | hit_card_stat | hit_card_en
                         | (reg_addr_i == AW'(OFF_TOP_STAT)) | (reg_addr_i == AW'(OFF_EXT_MASK));

    irq_hub_group #(.NSRC(N_EXT), .DW(DW), .SEN_POS(SEN_LSB)) u_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (ext_src_i),
        .wr_stat_i (reg_we_i & hit_ext_stat),
        .wr_en_i   (reg_we_i & hit_ext_en),
        .wdata_i   (reg_wdata_i),
        .status_o  (ext_stat),
        .ien_o     (ext_ien),
        .sen_o     (ext_sen),
        .summary_o (ext_sum)
    );

    irq_hub_group #(.NSRC(N_CARD), .DW(DW), .SEN_POS(SEN_LSB)) u_card (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (card_src_i),
        .wr_stat_i (reg_we_i & hit_card_stat),
        .wr_en_i   (reg_we_i & hit_card_en),
        .wdata_i   (reg_wdata_i),
        .status_o  (card_stat),
        .ien_o     (card_ien),
        .sen_o     (card_sen),
        .summary_o (card_sum)
    );

    always_comb begin
        hub_d = hub_q;
        if (reg_we_i && hit_master) begin
            hub_d.master = reg_wdata_i[0];
        end
        hub_d.irq = hub_q.master & (ext_sum | card_sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hub_q <= '0;
        end else begin
            hub_q <= hub_d;
        end
    end

    assign host_irq_o = hub_q.irq;

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            AW'(OFF_TOP_STAT): begin
                reg_rdata_o[TOP_CARD_BIT] = card_sum;
                reg_rdata_o[TOP_EXT_BIT]  = ext_sum;
            end
            AW'(OFF_MASTER):    reg_rdata_o[0] = hub_q.master;
            AW'(OFF_EXT_STAT):  reg_rdata_o[N_EXT-1:0] = ext_stat;
            AW'(OFF_EXT_MASK):  reg_rdata_o[N_EXT-1:0] = ext_stat & ext_ien;
            AW'(OFF_EXT_EN): begin
                reg_rdata_o[N_EXT-1:0]          = ext_ien;
                reg_rdata_o[SEN_LSB +: N_EXT]   = ext_sen;
            end
            AW'(OFF_CARD_STAT): reg_rdata_o[N_CARD-1:0] = card_stat;
            AW'(OFF_CARD_EN): begin
                reg_rdata_o[N_CARD-1:0]         = card_ien;
                reg_rdata_o[SEN_LSB +: N_CARD]  = card_sen;
            end
            default:            reg_rdata_o = '0;
        endcase
    end

    // R8: no request unless the master bit was set the cycle before
    a_r8_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hub_q.master) |-> !host_irq_o);

    // R8: no request unless some group summary was active the cycle before
    a_r8_needs_summary: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ext_sum | card_sum) |-> !host_irq_o);

    // R6: masked view never shows a source with its interrupt enable off
    a_r6_masked_view: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == AW'(OFF_EXT_MASK)) |-> ((reg_rdata_o & ~DW'(ext_ien)) == '0));

    // R10: holes in the map read as zero
    a_r10_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_hit |-> (reg_rdata_o == '0));

endmodule

// File: tb/tb_irq_hub_top.sv
module tb_irq_hub_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic [5:0]  ext_src = '0;
    logic [3:0]  card_src = '0;
    logic        host_irq;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [11:0] addr;
        logic [31:0] exp;
        string       req;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    irq_hub_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_we_i    (reg_we),
        .reg_rdata_o (reg_rdata),
        .ext_src_i   (ext_src),
        .card_src_i  (card_src),
        .host_irq_o  (host_irq)
    );

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            sb_item_t    it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {31'b0, host_irq} : reg_rdata;
            n_total++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.req, it.addr, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        tick();
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        tick();
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string req);
        sb_item_t it;
        tick();
        reg_addr = a;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.req = req;
        sb_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic chk_irq(input logic e, input string req);
        sb_item_t it;
        tick();
        it.is_irq = 1'b1; it.addr = '0; it.exp = {31'b0, e}; it.req = req;
        sb_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic set_ext(input logic [5:0] v);
        tick();
        ext_src = v;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd(12'h000, 32'h0, "R1 top status");
        rd(12'h010, 32'h0, "R1 master");
        rd(12'h100, 32'h0, "R1 ext status");
        rd(12'h110, 32'h0, "R1 ext enable");
        rd(12'h200, 32'h0, "R1 card status");
        rd(12'h210, 32'h0, "R1 card enable");
        chk_irq(1'b0, "R1 host line");

        // R9: enable layout
        wr(12'h110, 32'h0000_3F3F);
        rd(12'h110, 32'h0000_3F3F, "R9 ext enable layout");

        // R2/R9: edge on line 2 lands in bit 2
        set_ext(6'b000100);
        rd(12'h100, 32'h04, "R2 edge latched bit2");
        rd(12'h000, 32'h80, "R7 ext summary bit7");
        chk_irq(1'b0, "R8 master off");

        // R8: master on, one-cycle latency
        wr(12'h010, 32'h1);
        chk_irq(1'b1, "R8 host asserted");
        rd(12'h010, 32'h1, "R8 master readback");

        // R4: zero write keeps, one write clears; held level not re-latched (R2)
        wr(12'h100, 32'h0);
        rd(12'h100, 32'h04, "R4 zero write keeps");
        wr(12'h100, 32'h04);
        chk_irq(1'b0, "R4 clear drops host");
        rd(12'h100, 32'h00, "R2 held level not relatched");

        // R3: edge with status enable off is lost
        wr(12'h110, 32'h0000_003F);
        set_ext(6'b000000);
        set_ext(6'b000001);
        rd(12'h100, 32'h00, "R3 edge ignored sen off");
        wr(12'h110, 32'h0000_3F3F);
        rd(12'h100, 32'h00, "R3 no retroactive latch");

        // R6: masked view
        set_ext(6'b100001);
        rd(12'h100, 32'h20, "R9 line5 in bit5");
        wr(12'h110, 32'h0000_3F01);
        rd(12'h104, 32'h00, "R6 masked hides bit5");
        rd(12'h000, 32'h00, "R7 summary off when masked");
        chk_irq(1'b0, "R8 no summary no host");
        set_ext(6'b100000);
        set_ext(6'b100001);
        rd(12'h100, 32'h21, "R2 second source latched");
        rd(12'h104, 32'h01, "R6 masked shows bit0");
        rd(12'h000, 32'h80, "R7 ext summary");
        chk_irq(1'b1, "R8 host via bit0");

        // R5: set beats clear in the same cycle
        wr(12'h100, 32'h3F);
        set_ext(6'b000000);
        rd(12'h100, 32'h00, "R4 all cleared");
        tick();
        ext_src   = 6'b000010;
        reg_addr  = 12'h100;
        reg_wdata = 32'h02;
        reg_we    = 1'b1;
        tick();
        reg_we    = 1'b0;
        rd(12'h100, 32'h02, "R5 set wins over clear");

        // R9: card group ordering and summary bit 0
        wr(12'h210, 32'h0000_0F0F);
        rd(12'h210, 32'h0000_0F0F, "R9 card enable layout");
        tick();
        card_src = 4'b1010;
        rd(12'h200, 32'h0A, "R9 card ring bits");
        rd(12'h000, 32'h01, "R7 card summary bit0");

        // R10: holes and read-only offsets
        wr(12'h300, 32'hFFFF_FFFF);
        rd(12'h300, 32'h0, "R10 hole reads zero");
        rd(12'h014, 32'h0, "R10 near hole zero");
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, 32'h01, "R10 top status read-only");
        wr(12'h104, 32'hFFFF_FFFF);
        rd(12'h100, 32'h02, "R10 masked write no clear");
        rd(12'h200, 32'h0A, "R10 card untouched");

        // R8: master gating from the card side
        wr(12'h010, 32'h0);
        chk_irq(1'b0, "R8 master cleared");
        wr(12'h010, 32'hFFFF_FFFE);
        rd(12'h010, 32'h0, "R8 only bit0 stored");
        chk_irq(1'b0, "R8 still off");
        wr(12'h010, 32'h1);
        chk_irq(1'b1, "R8 card drives host");

        tick();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule